// File: doc/BRIEF.md
# Two-Write Reset Sequencer

This block watches a simple write bus and turns an ordered pair of writes into a system reset. The conventional way in is a single byte-wide reset-control port in I/O space: two successive writes to that port arm the sequencer and then trigger it. Bus masters that can only issue memory cycles use a second way in. Two consecutive word addresses near the top of the address space stand in for the port: the first write of the pair goes to the lower address and the second to the upper one.

A hard reset drives a CPU reset, an active-low PCI-style bus reset and an ISA-style reset drive together, and holds them for a parameter-set number of clocks. A soft reset drives only a CPU INIT pulse, which is shorter. While a pulse is running the sequencer ignores the bus. Its control byte can be read back at any time. Bus protocol handling, power-on reset and resets from outside the block are left to other logic.

Top module: `rstseq_top`

## Requirements
- R1: After reset `cpu_rst`, `isa_rstdrv` and `cpu_init` are 0, `pci_rst_n` is 1, and `ctrl_rdata` is 0x00.
- R2: An I/O write (`wr_io`=1) of 0x02 to port 0xCF9, followed by an I/O write of 0x06 to the same port, starts a hard reset. From the cycle after the second write, `cpu_rst` and `isa_rstdrv` are 1 and `pci_rst_n` is 0 for exactly HARD_CYCLES cycles (default 1024). `cpu_init` stays 0.
- R3: The pair 0x00 then 0x04 at port 0xCF9 starts a soft reset. From the cycle after the second write, `cpu_init` is 1 for exactly INIT_CYCLES cycles (default 16). The three hard-reset outputs stay inactive.
- R4: In memory mode (`wr_io`=0) the first write goes to 0xFFFFFFF0 and the second to 0xFFFFFFF4. The data rules and output timing of R2 and R3 apply unchanged.
- R5: A first write arms the sequencer only when data bit 2 is 0, and it records data bit 1 (1 = hard, 0 = soft). A second write fires only when its bit 2 is 1 and its bit 1 equals the recorded bit. Any other second write returns the sequencer to idle without a reset.
- R6: While armed, any decoded write that is not the valid second write disarms the sequencer without a reset. This covers a write to the wrong address of the pair, a write of the other cycle type, and a write with bit 2 clear. A later valid-looking second write then fires nothing.
- R7: Writes to undecoded addresses, and writes of the wrong cycle type to a decoded address value, have no effect. They do not disarm, and they do not change `ctrl_rdata`.
- R8: Writes presented while any reset output is active are ignored: no arming, no firing, and `ctrl_rdata` is unchanged. A write presented in the first cycle in which the outputs are inactive again is accepted.
- R9: `ctrl_rdata` shows, from the cycle after an accepted decoded write, that write's data byte with bit 2 forced to 0. Bit 1 therefore reads back as the hard/soft choice.
- R10: A write to the memory-mode second address while the sequencer is idle fires nothing and arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer itself |
| wr_en | input | 1 | Write strobe, one write per cycle in which it is high |
| wr_io | input | 1 | 1 = I/O-space write, 0 = memory-space write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| ctrl_rdata | output | 8 | Read-back of the control byte (bit 2 always 0) |
| cpu_rst | output | 1 | CPU reset, active high |
| pci_rst_n | output | 1 | Bus reset, active low |
| isa_rstdrv | output | 1 | Reset drive, active high |
| cpu_init | output | 1 | CPU INIT pulse, active high |

## Verification
A sequencer stuck in the armed state, or one that forgets the recorded hard/soft bit, shows up one cycle after the next second write: a reset pulse appears or is missing, or it appears on the wrong outputs. A pulse counter that is off by one shows at the single cycle where the outputs drop. Busy-state errors show as either a changed `ctrl_rdata` or a fresh pulse starting right after the old one ends. The bench runs a cycle-level model and compares every output in every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int unsigned CTRL_W = 8;
    localparam int unsigned HS_BIT = 1;   // hard (1) / soft (0) selector
    localparam int unsigned GO_BIT = 2;   // set on the triggering write

    typedef enum logic [1:0] {
        WK_NONE,
        WK_IO,
        WK_MEM_A,
        WK_MEM_B
    } wr_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARM_IO,
        SQ_ARM_MEM,
        SQ_BUSY
    } seq_state_e;

    typedef struct packed {
        seq_state_e              state;
        logic                    arm_hard;
        logic [CTRL_W-1:0]       ctrl;
    } seq_regs_t;

endpackage

// File: rtl/rstseq_decode.sv
module rstseq_decode
    import rstseq_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] IO_PORT    = ADDR_W'(32'h0000_0CF9),
    parameter logic [ADDR_W-1:0] MEM_ADDR_A = ADDR_W'(32'hFFFF_FFF0),
    parameter logic [ADDR_W-1:0] MEM_ADDR_B = ADDR_W'(32'hFFFF_FFF4)
) (
    input  logic              wr_en,
    input  logic              wr_io,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_kind_e          kind
);

    logic hit_io;
    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_io = wr_en &&  wr_io && (wr_addr == IO_PORT);
        hit_a  = wr_en && !wr_io && (wr_addr == MEM_ADDR_A);
        hit_b  = wr_en && !wr_io && (wr_addr == MEM_ADDR_B);
        if (hit_io)     kind = WK_IO;
        else if (hit_a) kind = WK_MEM_A;
        else if (hit_b) kind = WK_MEM_B;
        else            kind = WK_NONE;
    end

endmodule

// File: rtl/rstseq_seq.sv
module rstseq_seq
    import rstseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              pulse_busy,
    input  logic              pulse_last,
    output logic              fire_hard,
    output logic              fire_soft,
    output logic [CTRL_W-1:0] ctrl_rdata
);

    seq_regs_t seq_d, seq_q;
    logic      go;
    logic      hs;
    logic      ignore;

    always_comb begin
        seq_d     = seq_q;
        fire_hard = 1'b0;
        fire_soft = 1'b0;
        go        = wr_data[GO_BIT];
        hs        = wr_data[HS_BIT];
        ignore    = (seq_q.state == SQ_BUSY) || pulse_busy;

        if (seq_q.state == SQ_BUSY) begin
            if (pulse_last) seq_d.state = SQ_IDLE;
        end else if (!ignore && kind != WK_NONE) begin
            seq_d.ctrl         = wr_data;
            seq_d.ctrl[GO_BIT] = 1'b0;
            unique case (seq_q.state)
                SQ_IDLE: begin
                    if (!go && kind == WK_IO) begin
                        seq_d.state    = SQ_ARM_IO;
                        seq_d.arm_hard = hs;
                    end else if (!go && kind == WK_MEM_A) begin
                        seq_d.state    = SQ_ARM_MEM;
                        seq_d.arm_hard = hs;
                    end
                end
                SQ_ARM_IO, SQ_ARM_MEM: begin
                    seq_d.state = SQ_IDLE;
                    if (go && hs == seq_q.arm_hard &&
                        ((seq_q.state == SQ_ARM_IO  && kind == WK_IO) ||
                         (seq_q.state == SQ_ARM_MEM && kind == WK_MEM_B))) begin
                        seq_d.state = SQ_BUSY;
                        fire_hard   = seq_q.arm_hard;
                        fire_soft   = !seq_q.arm_hard;
                    end
                end
                default: seq_d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state    <= SQ_IDLE;
            seq_q.arm_hard <= 1'b0;
            seq_q.ctrl     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctrl_rdata = seq_q.ctrl;

    AST_BUSY_FREEZES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SQ_BUSY) |=> $stable(ctrl_rdata)); // R8
    AST_QUIET_UNLESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != SQ_BUSY) |-> !pulse_busy); // R8
    AST_ARMED_GO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SQ_ARM_IO || seq_q.state == SQ_ARM_MEM) |-> !ctrl_rdata[GO_BIT]); // R5

endmodule

// File: rtl/rstseq_pulse.sv
module rstseq_pulse #(
    parameter int unsigned HARD_CYCLES = 1024,
    parameter int unsigned INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_hard,
    input  logic fire_soft,
    output logic hard_on,
    output logic init_on,
    output logic busy,
    output logic last
);

    localparam int unsigned LONGEST = (HARD_CYCLES > INIT_CYCLES) ? HARD_CYCLES : INIT_CYCLES;
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    typedef struct packed {
        logic             hard;
        logic             init;
        logic [CNT_W-1:0] cnt;
    } pulse_regs_t;

    pulse_regs_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        busy = pl_q.hard || pl_q.init;
        last = busy && (pl_q.cnt == '0);
        if (busy) begin
            if (last) begin
                pl_d.hard = 1'b0;
                pl_d.init = 1'b0;
            end else begin
                pl_d.cnt = pl_q.cnt - 1'b1;
            end
        end else if (fire_hard) begin
            pl_d.hard = 1'b1;
            pl_d.cnt  = CNT_W'(HARD_CYCLES - 1);
        end else if (fire_soft) begin
            pl_d.init = 1'b1;
            pl_d.cnt  = CNT_W'(INIT_CYCLES - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_q.hard <= 1'b0;
            pl_q.init <= 1'b0;
            pl_q.cnt  <= '0;
        end else begin
            pl_q <= pl_d;
        end
    end

    assign hard_on = pl_q.hard;
    assign init_on = pl_q.init;

    AST_HARD_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_on) |-> $past(fire_hard)); // R2
    AST_INIT_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_on) |-> $past(fire_soft)); // R3
    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hard_on && init_on)); // R3
    AST_HARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_on && !last) |=> hard_on); // R2
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(fire_hard || fire_soft)); // R8

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] IO_PORT     = ADDR_W'(32'h0000_0CF9),
    parameter logic [ADDR_W-1:0] MEM_ADDR_A  = ADDR_W'(32'hFFFF_FFF0),
    parameter logic [ADDR_W-1:0] MEM_ADDR_B  = ADDR_W'(32'hFFFF_FFF4),
    parameter int unsigned       HARD_CYCLES = 1024,
    parameter int unsigned       INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_io,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        ctrl_rdata,
    output logic              cpu_rst,
    output logic              pci_rst_n,
    output logic              isa_rstdrv,
    output logic              cpu_init
);

    wr_kind_e kind;
    logic     fire_hard;
    logic     fire_soft;
    logic     hard_on;
    logic     init_on;
    logic     pulse_busy;
    logic     pulse_last;

    rstseq_decode #(
        .ADDR_W     (ADDR_W),
        .IO_PORT    (IO_PORT),
        .MEM_ADDR_A (MEM_ADDR_A),
        .MEM_ADDR_B (MEM_ADDR_B)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_io   (wr_io),
        .wr_addr (wr_addr),
        .kind    (kind)
    );

    rstseq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .wr_data    (wr_data),
        .pulse_busy (pulse_busy),
        .pulse_last (pulse_last),
        .fire_hard  (fire_hard),
        .fire_soft  (fire_soft),
        .ctrl_rdata (ctrl_rdata)
    );

    rstseq_pulse #(
        .HARD_CYCLES (HARD_CYCLES),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_hard (fire_hard),
        .fire_soft (fire_soft),
        .hard_on   (hard_on),
        .init_on   (init_on),
        .busy      (pulse_busy),
        .last      (pulse_last)
    );

    assign cpu_rst    = hard_on;
    assign isa_rstdrv = hard_on;
    assign pci_rst_n  = ~hard_on;
    assign cpu_init   = init_on;

    AST_RDATA_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ctrl_rdata) |-> (!ctrl_rdata[2] && $past(wr_en))); // R9

endmodule

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int HARD = 20;
    localparam int INIT = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        wr_io;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic [7:0]  ctrl_rdata;
    logic        cpu_rst, pci_rst_n, isa_rstdrv, cpu_init;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    int       m_st;      // 0 idle, 1 armed io, 2 armed mem
    bit       m_arm_hard;
    int       m_hcnt, m_icnt;
    bit [7:0] m_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstseq_top #(.HARD_CYCLES(HARD), .INIT_CYCLES(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_io(wr_io),
        .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_rdata(ctrl_rdata),
        .cpu_rst(cpu_rst), .pci_rst_n(pci_rst_n), .isa_rstdrv(isa_rstdrv),
        .cpu_init(cpu_init)
    );

    function automatic int classify(bit io, bit [31:0] a);
        if (io && a == 32'h0000_0CF9) return 1;
        if (!io && a == 32'hFFFF_FFF0) return 2;
        if (!io && a == 32'hFFFF_FFF4) return 3;
        return 0;
    endfunction

    task automatic model_edge();
        int k;
        if (m_hcnt != 0 || m_icnt != 0) begin
            if (m_hcnt != 0) m_hcnt--;
            if (m_icnt != 0) m_icnt--;
        end else if (wr_en) begin
            k = classify(wr_io, wr_addr);
            if (k != 0) begin
                m_reg = wr_data & 8'hFB;
                if (m_st == 0) begin
                    if (!wr_data[2] && k == 1) begin m_st = 1; m_arm_hard = wr_data[1]; end
                    else if (!wr_data[2] && k == 2) begin m_st = 2; m_arm_hard = wr_data[1]; end
                end else begin
                    if (wr_data[2] && wr_data[1] == m_arm_hard &&
                        ((m_st == 1 && k == 1) || (m_st == 2 && k == 3))) begin
                        if (m_arm_hard) m_hcnt = HARD; else m_icnt = INIT;
                    end
                    m_st = 0;
                end
            end
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "cpu_rst",    cpu_rst,    m_hcnt != 0);
        check(tag, "isa_rstdrv", isa_rstdrv, m_hcnt != 0);
        check(tag, "pci_rst_n",  pci_rst_n,  m_hcnt == 0);
        check(tag, "cpu_init",   cpu_init,   m_icnt != 0);
        check(tag, "ctrl_rdata", ctrl_rdata, m_reg);
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        #1;
        check_all(tag);
        wr_en = 1'b0;
    endtask

    task automatic wr(string tag, bit io, bit [31:0] a, bit [7:0] d);
        wr_en = 1'b1; wr_io = io; wr_addr = a; wr_data = d;
        step(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        int r;
        int sel;
        bit [7:0] d;
        rst_n = 1'b0; wr_en = 1'b0; wr_io = 1'b0; wr_addr = '0; wr_data = '0;
        m_st = 0; m_arm_hard = 0; m_hcnt = 0; m_icnt = 0; m_reg = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check_all("R1");

        // R2 hard via I/O port, R9 readback
        wr("R2", 1, 32'hCF9, 8'h02);
        check("R9", "readback bit1", ctrl_rdata[1], 1);
        wr("R2", 1, 32'hCF9, 8'h06);
        check("R9", "readback bit2", ctrl_rdata[2], 0);
        idle("R2", HARD + 2);

        // R3 soft via I/O port
        wr("R3", 1, 32'hCF9, 8'h00);
        wr("R3", 1, 32'hCF9, 8'h04);
        idle("R3", INIT + 2);

        // R4 memory mode, hard and soft
        wr("R4", 0, 32'hFFFF_FFF0, 8'h02);
        wr("R4", 0, 32'hFFFF_FFF4, 8'h06);
        idle("R4", HARD + 1);
        wr("R4", 0, 32'hFFFF_FFF0, 8'h00);
        wr("R4", 0, 32'hFFFF_FFF4, 8'h04);
        idle("R4", INIT + 1);

        // R5 mismatch and bad first write
        wr("R5", 1, 32'hCF9, 8'h02);
        wr("R5", 1, 32'hCF9, 8'h04);
        wr("R5", 1, 32'hCF9, 8'h06);
        wr("R5", 1, 32'hCF9, 8'h06);
        idle("R5", 3);

        // R6 disarm by other decoded writes
        wr("R6", 1, 32'hCF9, 8'h02);
        wr("R6", 0, 32'hFFFF_FFF0, 8'h02);
        wr("R6", 1, 32'hCF9, 8'h06);
        wr("R6", 0, 32'hFFFF_FFF0, 8'h00);
        wr("R6", 1, 32'hCF9, 8'h04);
        wr("R6", 0, 32'hFFFF_FFF4, 8'h04);
        wr("R6", 1, 32'hCF9, 8'h02);
        wr("R6", 1, 32'hCF9, 8'h02);
        wr("R6", 1, 32'hCF9, 8'h06);
        idle("R6", 3);

        // R7 undecoded writes leave armed state and readback alone
        wr("R7", 1, 32'hCF9, 8'h02);
        wr("R7", 1, 32'hCF8, 8'hFF);
        wr("R7", 0, 32'h0000_0CF9, 8'h00);
        wr("R7", 1, 32'hFFFF_FFF4, 8'h04);
        check("R7", "readback kept", ctrl_rdata, 8'h02);
        wr("R7", 1, 32'hCF9, 8'h06);
        idle("R7", HARD + 1);

        // R8 writes during pulse ignored, accepted right after
        wr("R8", 1, 32'hCF9, 8'h02);
        wr("R8", 1, 32'hCF9, 8'h06);
        wr("R8", 1, 32'hCF9, 8'h00);
        wr("R8", 1, 32'hCF9, 8'h04);
        idle("R8", HARD - 3);
        wr("R8", 1, 32'hCF9, 8'h80);   // last active cycle: ignored
        check("R8", "readback during pulse", ctrl_rdata, 8'h02);
        wr("R8", 1, 32'hCF9, 8'h00);   // first quiet cycle: accepted
        wr("R8", 1, 32'hCF9, 8'h04);
        idle("R8", INIT + 1);

        // R10 second memory address alone
        wr("R10", 0, 32'hFFFF_FFF4, 8'h06);
        wr("R10", 0, 32'hFFFF_FFF4, 8'h04);
        idle("R10", 2);

        // constrained random mix
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            r = int'($urandom % 4);
            sel = int'($urandom % 6);
            case (int'($urandom % 6))
                0: d = 8'h00; 1: d = 8'h02; 2: d = 8'h04; 3: d = 8'h06;
                default: d = 8'($urandom);
            endcase
            if (r == 0) begin
                step("R6");
            end else begin
                case (sel)
                    0, 1: wr("R6", 1, 32'hCF9, d);
                    2:    wr("R6", 0, 32'hFFFF_FFF0, d);
                    3:    wr("R6", 0, 32'hFFFF_FFF4, d);
                    4:    wr("R7", 0, 32'h0000_0CF9, d);
                    default: wr("R7", 1, 32'hFFFF_FFF0, d);
                endcase
            end
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule